// File: doc/BRIEF.md
# Octet-Stream Frame Receiver with Flag Delimiting and FCS-32 Check

This block sits after a SONET/SDH framer. It takes a byte-aligned octet stream, one byte per clock, qualified by a strobe. It can undo a self-synchronizing x^43+1 scrambler that covers both frame contents and the idle flags between frames. It then finds frame boundaries on flag bytes, removes escape stuffing and checks a 32-bit frame check sequence over the unstuffed frame. Packets leave on an 8-bit output that carries start, end and error markers and follows the sink's ready signal.

A frame is every byte between two flags. It is opened by the first non-flag byte after one or more flags. Runs of flags yield nothing. Errors such as a bad check sequence, a frame that is too short or an abort sequence are reported on the last delivered byte of the packet. Two static configuration inputs select descrambling and the removal of the four check-sequence bytes. They may change only while the line is idle.

Top module: `octet_frame_rx`

## Requirements
- R1: After reset `pkt_valid` is low, and every input byte is ignored until the first 0x7E flag has been seen.
- R2: With `cfg_descramble_en`=1 each received bit is XORed with the received bit 43 bit-times earlier, bit 7 of a byte being the earliest in time. The history also advances while descrambling is off. With `cfg_descramble_en`=0 bytes pass through unchanged.
- R3: A frame opens on the first non-flag byte after one or more 0x7E flags. Consecutive flags produce no packet, and one flag can both close a frame and open the next.
- R4: A 0x7D escape is dropped and the byte after it is XORed with 0x20. This happens before the byte is delivered or added to the check sequence.
- R5: The FCS-32 (reflected polynomial 0xEDB88320, preset 0xFFFFFFFF) is run over all unstuffed frame bytes, the check bytes included. Any result other than 0xDEBB20E3 sets `pkt_err` on the end-of-packet byte.
- R6: With `cfg_strip_fcs`=1 the last four unstuffed bytes of a frame are not delivered. With `cfg_strip_fcs`=0 every unstuffed byte is delivered.
- R7: A 0x7D immediately followed by 0x7E aborts the frame. The packet ends with `pkt_eop` and `pkt_err`.
- R8: A frame of fewer than 4 unstuffed bytes is flagged with `pkt_err`. A frame that ends with no byte left to deliver produces a single 0x00 byte with `pkt_sop`, `pkt_eop` and `pkt_err` all set.
- R9: `pkt_sop` marks the first byte of each packet and `pkt_eop` its last. `pkt_err` is only ever set together with `pkt_eop`.
- R10: While `pkt_valid` is high and `pkt_ready` is low, the output byte and its markers stay unchanged.
- R11: Cycles with `rx_valid` low have no effect on the delivered packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_descramble_en | input | 1 | 1 = descramble the input stream, 0 = bypass |
| cfg_strip_fcs | input | 1 | 1 = drop the four check bytes from delivered packets |
| rx_data | input | 8 | Received octet |
| rx_valid | input | 1 | `rx_data` carries a byte this cycle |
| pkt_data | output | 8 | Delivered packet byte |
| pkt_valid | output | 1 | `pkt_data` and markers are valid |
| pkt_sop | output | 1 | First byte of a packet |
| pkt_eop | output | 1 | Last byte of a packet |
| pkt_err | output | 1 | Packet is bad (only with `pkt_eop`) |
| pkt_ready | input | 1 | Sink accepts the presented byte |

## Verification
The assertions check the following on every cycle: descrambler bypass, silence while hunting for the first flag, the marker rules on the output (no error without end, start only at a packet boundary), the empty-frame marker byte, and that a stalled output holds. Only the bench scenarios can show the correct check-sequence verdict over real frames, unstuffing of flag and escape values inside payloads, FCS removal in both modes, and short and aborted frames. The same holds for descrambling against an independent scrambler model, and for the absence of packets from runs of flags.

// File: rtl/frx_pkg.sv
// Shared constants, state type and FCS-32 step function for the frame receiver.
package frx_pkg;
    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [7:0]  ESC_BYTE   = 8'h7D;
    localparam logic [7:0]  ESC_XOR    = 8'h20;
    localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_GOOD   = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        ST_HUNT,   // no flag seen yet
        ST_IDLE,   // between frames, after a flag
        ST_FRAME,  // inside a frame
        ST_ESC     // escape byte received, next byte is transformed
    } link_state_t;

    // One byte of the reflected FCS-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in ^ {24'h0, data};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/frx_descrambler.sv
// Self-synchronizing descrambler, polynomial x^LAG + 1, applied to whole bytes.
// Assumes LAG > BYTE_W and that bit BYTE_W-1 is the earliest bit in time.
// The history always holds the raw received bits, so enabling it needs no resync.
module frx_descrambler #(
    parameter int BYTE_W = 8,
    parameter int LAG    = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid
);
    localparam int KEEP_W = LAG - BYTE_W;

    logic [LAG-1:0]    hist_q;
    logic [BYTE_W-1:0] mask;

    // Each bit's partner lies exactly LAG bit-times earlier, all within the history.
    for (genvar j = 0; j < BYTE_W; j++) begin : g_tap
        assign mask[j] = enable & hist_q[KEEP_W + j];
    end

    // Register the descrambled byte and advance the raw-bit history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q    <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hist_q   <= {hist_q[KEEP_W-1:0], in_data};
                out_data <= in_data ^ mask;
            end
        end
    end

    // R2: bypass leaves the byte untouched, one cycle later
    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !enable) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/frx_deframer.sv
// Flag delimiting and escape removal. Consumes one byte per strobe and reports
// frame start, unstuffed content bytes, and frame close (normal or abort).
// Assumes upstream byte alignment.
module frx_deframer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] byte_in,
    input  logic       byte_valid,
    output logic       frame_start,
    output logic       content_valid,
    output logic [7:0] content_data,
    output logic       close_valid,
    output logic       close_abort
);
    import frx_pkg::*;

    link_state_t st_q, st_d;

    // Decode the incoming byte against the link state.
    always_comb begin
        st_d          = st_q;
        frame_start   = 1'b0;
        content_valid = 1'b0;
        content_data  = byte_in;
        close_valid   = 1'b0;
        close_abort   = 1'b0;
        if (byte_valid) begin
            case (st_q)
                ST_HUNT: begin
                    if (byte_in == FLAG_BYTE) st_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (byte_in == ESC_BYTE) begin
                        frame_start = 1'b1;
                        st_d        = ST_ESC;
                    end else if (byte_in != FLAG_BYTE) begin
                        frame_start   = 1'b1;
                        content_valid = 1'b1;
                        st_d          = ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (byte_in == FLAG_BYTE) begin
                        close_valid = 1'b1;
                        st_d        = ST_IDLE;
                    end else if (byte_in == ESC_BYTE) begin
                        st_d = ST_ESC;
                    end else begin
                        content_valid = 1'b1;
                    end
                end
                default: begin
                    if (byte_in == FLAG_BYTE) begin
                        close_valid = 1'b1;
                        close_abort = 1'b1;
                        st_d        = ST_IDLE;
                    end else begin
                        content_valid = 1'b1;
                        content_data  = byte_in ^ ESC_XOR;
                        st_d          = ST_FRAME;
                    end
                end
            endcase
        end
    end

    // Hold the link state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // R1: nothing leaves the deframer before the first flag
    assert_hunt_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT) |-> (!content_valid && !close_valid && !frame_start));
endmodule

// File: rtl/frx_fcs_check.sv
// Running FCS-32 and saturating length count over the unstuffed frame bytes.
// Verdicts are valid in the cycle of a close event, which always follows the
// last content byte by at least one strobe.
module frx_fcs_check #(
    parameter int MIN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       content_valid,
    input  logic [7:0] content_data,
    output logic       crc_good,
    output logic       too_short
);
    import frx_pkg::*;

    localparam int LEN_W = $clog2(MIN_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MIN_LEN);

    logic [31:0]      crc_q, crc_base;
    logic [LEN_W-1:0] len_q, len_base;

    assign crc_base  = frame_start ? CRC_PRESET : crc_q;
    assign len_base  = frame_start ? '0 : len_q;
    assign crc_good  = (crc_q == CRC_GOOD);
    assign too_short = (len_q < LEN_SAT);

    // Accumulate check sequence and length; restart on each frame opening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
            len_q <= '0;
        end else if (content_valid) begin
            crc_q <= crc32_step(crc_base, content_data);
            len_q <= (len_base == LEN_SAT) ? len_base : len_base + 1'b1;
        end else if (frame_start) begin
            crc_q <= CRC_PRESET;
            len_q <= '0;
        end
    end

    // R8: a frame opening with a content byte has counted exactly one byte
    assert_len_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && content_valid) |=> (len_q == LEN_W'(1)));
endmodule

// File: rtl/frx_packer.sv
// Builds packets from content bytes. A HOLD-deep line withholds the last HOLD
// bytes when stripping, and a one-byte pending slot lets the close event tag the
// final byte with end and error. Assumes the sink accepts each byte before the
// next one is produced; a stalled byte is replaced by a newer one otherwise.
module frx_packer #(
    parameter int BYTE_W = 8,
    parameter int HOLD   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strip_en,
    input  logic              frame_start,
    input  logic              content_valid,
    input  logic [BYTE_W-1:0] content_data,
    input  logic              close_valid,
    input  logic              close_bad,
    output logic [BYTE_W-1:0] pkt_data,
    output logic              pkt_valid,
    output logic              pkt_sop,
    output logic              pkt_eop,
    output logic              pkt_err,
    input  logic              pkt_ready
);
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD);

    logic [BYTE_W-1:0] line_q [HOLD];
    logic [CNT_W-1:0]  fill_q, fill_base;
    logic              shift_full, new_pend;
    logic [BYTE_W-1:0] new_pend_data;
    logic              pend_valid, pend_first;
    logic [BYTE_W-1:0] pend_data;
    logic              emit, emit_sop, emit_eop, emit_err;
    logic [BYTE_W-1:0] emit_data;
    logic              in_pkt;

    assign fill_base     = frame_start ? '0 : fill_q;
    assign shift_full    = strip_en && (fill_base == FULL);
    assign new_pend      = content_valid && (!strip_en || shift_full);
    assign new_pend_data = strip_en ? line_q[0] : content_data;

    // Pick what, if anything, goes to the output register this cycle.
    always_comb begin
        emit      = 1'b0;
        emit_data = '0;
        emit_sop  = 1'b0;
        emit_eop  = 1'b0;
        emit_err  = 1'b0;
        if (close_valid) begin
            emit     = 1'b1;
            emit_eop = 1'b1;
            if (pend_valid) begin
                emit_data = pend_data;
                emit_sop  = pend_first;
                emit_err  = close_bad;
            end else begin
                emit_sop = 1'b1;
                emit_err = 1'b1;
            end
        end else if (new_pend && pend_valid) begin
            emit      = 1'b1;
            emit_data = pend_data;
            emit_sop  = pend_first;
        end
    end

    // Fill or shift the withholding line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HOLD; i++) line_q[i] <= '0;
            fill_q <= '0;
        end else if (close_valid) begin
            fill_q <= '0;
        end else if (content_valid && strip_en) begin
            if (!shift_full) begin
                for (int i = 0; i < HOLD; i++) begin
                    if (fill_base == CNT_W'(i)) line_q[i] <= content_data;
                end
                fill_q <= fill_base + 1'b1;
            end else begin
                for (int i = 0; i < HOLD - 1; i++) line_q[i] <= line_q[i+1];
                line_q[HOLD-1] <= content_data;
                fill_q <= FULL;
            end
        end else if (frame_start) begin
            fill_q <= '0;
        end
    end

    // Keep the one byte that waits to learn whether it ends the packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_first <= 1'b0;
            pend_data  <= '0;
        end else if (close_valid) begin
            pend_valid <= 1'b0;
        end else if (new_pend) begin
            pend_valid <= 1'b1;
            pend_first <= !pend_valid;
            pend_data  <= new_pend_data;
        end
    end

    // Output register with ready-based hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid <= 1'b0;
            pkt_data  <= '0;
            pkt_sop   <= 1'b0;
            pkt_eop   <= 1'b0;
            pkt_err   <= 1'b0;
        end else if (emit) begin
            pkt_valid <= 1'b1;
            pkt_data  <= emit_data;
            pkt_sop   <= emit_sop;
            pkt_eop   <= emit_eop;
            pkt_err   <= emit_err;
        end else if (pkt_ready) begin
            pkt_valid <= 1'b0;
        end
    end

    // Track whether an accepted packet is still open, for the marker checks.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      in_pkt <= 1'b0;
        else if (pkt_valid && pkt_ready && pkt_eop)      in_pkt <= 1'b0;
        else if (pkt_valid && pkt_ready && pkt_sop)      in_pkt <= 1'b1;
    end

    // R10: a stalled byte holds while nothing newer arrives
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready && !emit) |=>
        (pkt_valid && $stable(pkt_data) && $stable(pkt_sop) && $stable(pkt_eop) && $stable(pkt_err)));

    // R9: error is only reported on the closing byte
    assert_err_on_eop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_err) |-> pkt_eop);

    // R9: start marker exactly at packet boundaries
    assert_sop_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_sop == !in_pkt));

    // R8: a frame closing with nothing pending yields the lone error marker byte
    assert_empty_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (close_valid && !pend_valid) |=>
        (pkt_valid && pkt_sop && pkt_eop && pkt_err && pkt_data == '0));
endmodule

// File: rtl/octet_frame_rx.sv
// Top: descrambler -> deframer -> (FCS checker, packer). One octet per strobe.
// Assumes byte-aligned input and configuration changed only while idle.
module octet_frame_rx #(
    parameter int BYTE_W    = 8,
    parameter int SCR_LAG   = 43,
    parameter int FCS_BYTES = 4,
    parameter int MIN_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_descramble_en,
    input  logic              cfg_strip_fcs,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic [BYTE_W-1:0] pkt_data,
    output logic              pkt_valid,
    output logic              pkt_sop,
    output logic              pkt_eop,
    output logic              pkt_err,
    input  logic              pkt_ready
);
    logic [BYTE_W-1:0] ds_data;
    logic              ds_valid;
    logic              f_start, f_cvalid, f_close, f_abort;
    logic [BYTE_W-1:0] f_cdata;
    logic              crc_good, too_short, close_bad;

    assign close_bad = f_abort | !crc_good | too_short;

    frx_descrambler #(.BYTE_W(BYTE_W), .LAG(SCR_LAG)) u_descr (
        .clk(clk), .rst_n(rst_n), .enable(cfg_descramble_en),
        .in_data(rx_data), .in_valid(rx_valid),
        .out_data(ds_data), .out_valid(ds_valid)
    );

    frx_deframer u_deframe (
        .clk(clk), .rst_n(rst_n), .byte_in(ds_data), .byte_valid(ds_valid),
        .frame_start(f_start), .content_valid(f_cvalid), .content_data(f_cdata),
        .close_valid(f_close), .close_abort(f_abort)
    );

    frx_fcs_check #(.MIN_LEN(MIN_LEN)) u_fcs (
        .clk(clk), .rst_n(rst_n), .frame_start(f_start),
        .content_valid(f_cvalid), .content_data(f_cdata),
        .crc_good(crc_good), .too_short(too_short)
    );

    frx_packer #(.BYTE_W(BYTE_W), .HOLD(FCS_BYTES)) u_pack (
        .clk(clk), .rst_n(rst_n), .strip_en(cfg_strip_fcs),
        .frame_start(f_start), .content_valid(f_cvalid), .content_data(f_cdata),
        .close_valid(f_close), .close_bad(close_bad),
        .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
        .pkt_eop(pkt_eop), .pkt_err(pkt_err), .pkt_ready(pkt_ready)
    );
endmodule

// File: tb/octet_frame_rx_test.sv
`timescale 1ns/1ps
module octet_frame_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_descramble_en = 1'b0;
    logic       cfg_strip_fcs = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] pkt_data;
    logic       pkt_valid, pkt_sop, pkt_eop, pkt_err;
    logic       pkt_ready = 1'b1;

    always #2 clk = ~clk;

    octet_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .cfg_descramble_en(cfg_descramble_en),
        .cfg_strip_fcs(cfg_strip_fcs), .rx_data(rx_data), .rx_valid(rx_valid),
        .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
        .pkt_eop(pkt_eop), .pkt_err(pkt_err), .pkt_ready(pkt_ready)
    );

    int          errors = 0;
    int          checks = 0;
    string       cur_req = "R1";
    logic [10:0] exp_q[$];          // {sop, eop, err, data}
    logic [7:0]  pay[$];
    logic [42:0] scr_hist = '0;
    bit          scr_on = 0;
    int          gap_min = 0, gap_max = 0;
    bit          stall_mode = 0, ready_low_prev = 0, done = 0;
    bit          hold_prev = 0;
    logic [11:0] hold_snap;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
        c ^= {24'h0, b};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    // Scramble (x^43+1, MSB first) when enabled, then drive one byte plus a gap.
    task automatic send_raw(logic [7:0] b);
        logic [7:0] s;
        int g;
        s = scr_on ? (b ^ scr_hist[42:35]) : b;
        scr_hist = {scr_hist[34:0], s};
        rx_data  = s;
        rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        g = gap_min + ((gap_max > gap_min) ? $urandom_range(gap_max - gap_min) : 0);
        repeat (g) begin @(posedge clk); #1; end
    endtask

    // Expected packet from unstuffed frame contents (R5, R6, R7, R8, R9).
    task automatic expect_content(input logic [7:0] c[$], input bit abort);
        int n, keep;
        logic [31:0] crc;
        bit bad;
        n = c.size();
        if (n == 0 && !abort) return;
        crc = 32'hFFFFFFFF;
        foreach (c[i]) crc = crc_step(crc, c[i]);
        bad  = abort || (n < 4) || (crc != 32'hDEBB20E3);
        keep = cfg_strip_fcs ? n - 4 : n;
        if (keep <= 0) exp_q.push_back({3'b111, 8'h00});
        else for (int i = 0; i < keep; i++)
            exp_q.push_back({(i == 0), (i == keep - 1), (i == keep - 1) && bad, c[i]});
    endtask

    // mode 0 good FCS, 1 corrupted FCS, 2 abort, 3 raw bytes without FCS
    task automatic send_frame(int mode);
        logic [7:0] c[$];
        logic [31:0] f;
        c = pay;
        if (mode < 2) begin
            f = 32'hFFFFFFFF;
            foreach (c[i]) f = crc_step(f, c[i]);
            f = ~f;
            if (mode == 1) f ^= 32'h0000_0100;
            c.push_back(f[7:0]);   c.push_back(f[15:8]);
            c.push_back(f[23:16]); c.push_back(f[31:24]);
        end
        expect_content(c, mode == 2);
        foreach (c[i]) begin
            if (c[i] == 8'h7E || c[i] == 8'h7D) begin
                send_raw(8'h7D);
                send_raw(c[i] ^ 8'h20);
            end else send_raw(c[i]);
        end
        if (mode == 2) send_raw(8'h7D);
        send_raw(8'h7E);
    endtask

    task automatic rand_pay(int len, bit special);
        pay.delete();
        for (int i = 0; i < len; i++) begin
            if (special && $urandom_range(3) == 0) pay.push_back($urandom_range(1) ? 8'h7E : 8'h7D);
            else pay.push_back(8'($urandom_range(255)));
        end
    endtask

    task automatic drain(string req);
        repeat (16) begin @(posedge clk); #1; end
        check(exp_q.size() == 0, req, "undelivered expected bytes", exp_q.size(), 0);
    endtask

    // Ready pattern: random in stall mode but never low two cycles in a row.
    initial forever begin
        @(posedge clk); #1;
        if (stall_mode) pkt_ready = ready_low_prev ? 1'b1 : ($urandom_range(1) == 1);
        else pkt_ready = 1'b1;
        ready_low_prev = !pkt_ready;
    end

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_prev)   // R10
                check(pkt_valid && ({pkt_sop, pkt_eop, pkt_err, pkt_data} == hold_snap[10:0]),
                      "R10", "stalled byte changed", {pkt_valid, pkt_sop, pkt_eop, pkt_err, pkt_data},
                      {1'b1, hold_snap[10:0]});
            hold_prev = pkt_valid && !pkt_ready;
            hold_snap = {1'b0, pkt_sop, pkt_eop, pkt_err, pkt_data};
            if (pkt_valid && pkt_ready) begin
                if (exp_q.size() == 0)
                    check(0, cur_req, "unexpected byte", {pkt_sop, pkt_eop, pkt_err, pkt_data}, 0);
                else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    // R9: markers compared with every byte
                    check({pkt_sop, pkt_eop, pkt_err, pkt_data} == e, {cur_req, "/R9"},
                          "byte {sop,eop,err,data}", {pkt_sop, pkt_eop, pkt_err, pkt_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog actual=timeout expected=completion", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(pkt_valid == 1'b0, "R1", "pkt_valid after reset", pkt_valid, 0);
        @(posedge clk); #1;

        // R1: junk before the first flag is ignored
        cur_req = "R1";
        send_raw(8'h11); send_raw(8'h7D); send_raw(8'h55); send_raw(8'h7D);
        drain("R1");
        send_raw(8'h7E);
        rand_pay(6, 0); send_frame(0);
        drain("R1");

        // R3: flag runs and shared flags
        cur_req = "R3";
        repeat (5) send_raw(8'h7E);
        rand_pay(8, 0); send_frame(0);
        rand_pay(3, 0); send_frame(0);
        send_raw(8'h7E); send_raw(8'h7E);
        rand_pay(10, 0); send_frame(0);
        drain("R3");

        // R4: payloads full of flag and escape values
        cur_req = "R4";
        pay = '{8'h7E, 8'h7D, 8'h20, 8'h5E, 8'h5D, 8'h7E, 8'h7E, 8'h7D};
        send_frame(0);
        rand_pay(20, 1); send_frame(0);
        drain("R4");

        // R6: FCS bytes delivered when stripping is off
        cur_req = "R6";
        cfg_strip_fcs = 1'b0;
        send_raw(8'h7E);
        rand_pay(5, 0); send_frame(0);
        rand_pay(12, 1); send_frame(0);
        drain("R6");

        // R5: corrupted check sequence in both strip modes
        cur_req = "R5";
        rand_pay(9, 0); send_frame(1);
        drain("R5");
        cfg_strip_fcs = 1'b1;
        rand_pay(9, 1); send_frame(1);
        rand_pay(15, 0); send_frame(0);
        drain("R5");

        // R7: aborts, long and empty, both strip modes
        cur_req = "R7";
        rand_pay(12, 0); send_frame(2);
        pay.delete(); send_frame(2);
        drain("R7");
        cfg_strip_fcs = 1'b0;
        rand_pay(3, 0); send_frame(2);
        rand_pay(7, 1); send_frame(2);
        drain("R7");

        // R8: short frames and frames with nothing left after stripping
        cur_req = "R8";
        for (int len = 1; len <= 3; len++) begin rand_pay(len, 0); send_frame(3); end
        drain("R8");
        cfg_strip_fcs = 1'b1;
        for (int len = 1; len <= 3; len++) begin rand_pay(len, 0); send_frame(3); end
        pay.delete(); send_frame(0);
        rand_pay(1, 0); send_frame(0);
        drain("R8");

        // R11: idle cycles between strobes
        cur_req = "R11";
        gap_max = 3;
        for (int i = 0; i < 6; i++) begin rand_pay($urandom_range(1, 24), 1); send_frame($urandom_range(1)); end
        gap_max = 0;
        drain("R11");

        // R2: descrambling on, bench scrambles everything including flags
        cur_req = "R2";
        cfg_descramble_en = 1'b1; scr_on = 1;
        repeat (3) send_raw(8'h7E);
        for (int i = 0; i < 8; i++) begin rand_pay($urandom_range(1, 30), 1); send_frame($urandom_range(2)); end
        drain("R2");
        cfg_descramble_en = 1'b0; scr_on = 0;
        send_raw(8'h7E);
        rand_pay(6, 0); send_frame(0);
        drain("R2");

        // R10: sink stalls
        cur_req = "R10";
        stall_mode = 1; gap_min = 2; gap_max = 4;
        for (int i = 0; i < 8; i++) begin rand_pay($urandom_range(1, 20), 1); send_frame($urandom_range(3)); end
        drain("R10");
        stall_mode = 0; gap_min = 0; gap_max = 0;
        drain("R10");

        // Random mix across modes
        cur_req = "R5";
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(3) == 0) begin
                drain("R6");
                cfg_strip_fcs = $urandom_range(1);
            end
            if ($urandom_range(4) == 0) send_raw(8'h7E);
            rand_pay($urandom_range(0, 40), $urandom_range(1));
            send_frame($urandom_range(3));
        end
        drain("R5");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule